// File: doc/BRIEF.md
# Local Bus Cycle Controller with Hold and Backoff

This block is the master end of a local processor bus. It takes one read or write request at a time from an internal port and runs it on the bus. The first clock of a cycle is the address phase, marked by a one-clock start strobe. Data phases follow until the active-low ready input is sampled low. Each cycle presents an address, a write/read flag and a memory/IO flag. Write data is driven only while a write cycle is in flight.

The controller gives up the bus in two ways. When a hold request arrives, the cycle in progress runs to completion. The controller then floats the address, data and control enables and raises hold-acknowledge. When the active-low backoff input is sampled low, the running cycle is abandoned in the same clock and the bus floats at once. The abandoned cycle stays in the controller and is replayed from its address phase after backoff is released. A bus-request output stays high for as long as a cycle is outstanding. Backoff outranks hold, and hold-acknowledge is never given while a cycle remains outstanding.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While rst_ni is low, addr_oe_o, data_oe_o, ctrl_oe_o, hlda_o, bus_req_o and bus_start_o are all 0.
- R2: req_ready_o is 1 only when the controller is idle, has no outstanding cycle, and samples hold_i low and boff_ni high. In the clock after a request is accepted, bus_start_o is 1 for one clock, and bus_addr_o, bus_write_o and bus_mem_o carry the request. data_oe_o equals the write flag (1 = write, 0 = read), and bus_wdata_o carries the write data.
- R3: Each clock in which bus_rdy_ni is sampled high during a data phase adds one wait state. During a wait state bus_start_o is 0, addr_oe_o is 1 and the address is held. rsp_valid_o is 1 only in the clock where bus_rdy_ni is low in a data phase with boff_ni high. In that clock, for a read, rsp_rdata_o equals bus_rdata_i.
- R4: bus_req_o is 1 from the clock after acceptance until the clock after the cycle completes, and then returns to 0.
- R5: When hold_i is high as a cycle completes, then in the next clock hlda_o is 1, bus_req_o is 0 and all three enables are 0. A hold request seen while idle with no outstanding cycle gives the same result one clock later.
- R6: In the clock after hold_i is sampled low while held, hlda_o is 0 and addr_oe_o and ctrl_oe_o are 1.
- R7: If boff_ni is sampled low during an address or data phase, then from the next clock all enables are 0, bus_req_o stays 1 and hlda_o stays 0. No response is given even when bus_rdy_ni is low in the same clock.
- R8: In the clock after boff_ni is sampled high again, the aborted cycle restarts with bus_start_o and the same address and flags. Exactly one response is given per accepted request.
- R9: Backoff takes priority over hold. While backed off, hlda_o stays 0. If a cycle is outstanding, hlda_o is given only after that cycle has been replayed and has completed. If no cycle is outstanding, hlda_o is given in the clock after backoff is released while hold_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Internal request present |
| req_ready_o | output | 1 | Request accepted on this clock edge |
| req_addr_i | input | AW | Request address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_mem_i | input | 1 | 1 = memory, 0 = IO |
| req_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | Cycle completes this clock |
| rsp_rdata_o | output | DW | Read data, valid with rsp_valid_o |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | DW | Bus write data |
| bus_rdata_i | input | DW | Bus read data |
| bus_write_o | output | 1 | Write/read indication |
| bus_mem_o | output | 1 | Memory/IO indication |
| bus_start_o | output | 1 | Address-phase strobe |
| bus_rdy_ni | input | 1 | Ready, active low |
| bus_req_o | output | 1 | Bus request |
| hold_i | input | 1 | Hold request |
| hlda_o | output | 1 | Hold acknowledge |
| boff_ni | input | 1 | Backoff, active low |
| addr_oe_o | output | 1 | Address driver enable |
| data_oe_o | output | 1 | Write-data driver enable |
| ctrl_oe_o | output | 1 | Control driver enable |

## Verification
The embedded assertions check a set of rules on every clock. A wait state keeps the data phase. Backoff during a phase forces the aborted state. A held state never has an outstanding cycle. Hold release returns to idle in one clock. A response lasts one clock. Acknowledge and driven enables never overlap. A held cycle keeps its fields until it is cleared. The ordering across whole cycles can only be shown by the bench's scenarios. These include replay after an abort with matching fields, one response per request, backoff arriving together with ready, and hold arriving during a cycle or an abort and being acknowledged only after the replayed cycle ends.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_HELD,
    ST_BOFF
  } bcc_state_e;

  function automatic logic drives_bus(input bcc_state_e s);
    return (s == ST_IDLE) || (s == ST_ADDR) || (s == ST_DATA);
  endfunction

  function automatic logic in_cycle(input bcc_state_e s);
    return (s == ST_ADDR) || (s == ST_DATA);
  endfunction
endpackage

// File: rtl/bcc_cycle_reg.sv
module bcc_cycle_reg #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          clear_i,
  input  logic [AW-1:0] addr_i,
  input  logic          write_i,
  input  logic          mem_i,
  input  logic [DW-1:0] wdata_i,
  output logic          pend_o,
  output logic [AW-1:0] addr_o,
  output logic          write_o,
  output logic          mem_o,
  output logic [DW-1:0] wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o  <= 1'b0;
      addr_o  <= '0;
      write_o <= 1'b0;
      mem_o   <= 1'b0;
      wdata_o <= '0;
    end else if (load_i) begin
      pend_o  <= 1'b1;
      addr_o  <= addr_i;
      write_o <= write_i;
      mem_o   <= mem_i;
      wdata_o <= wdata_i;
    end else if (clear_i) begin
      pend_o <= 1'b0;
    end
  end

  AST_LOAD_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !pend_o); // R2

  // aborted cycle survives until it completes
  AST_KEEP_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !clear_i) |=> (pend_o && $stable(addr_o) && $stable(write_o) && $stable(mem_o))); // R8
endmodule

// File: rtl/bcc_fsm.sv
module bcc_fsm import bcc_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic       pend_i,
  input  logic       rdy_ni,
  input  logic       hold_i,
  input  logic       boff_ni,
  output bcc_state_e state_d_o,
  output logic       load_o,
  output logic       clear_o,
  output logic       req_ready_o,
  output logic       rsp_valid_o
);
  bcc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    clear_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (!boff_ni)         state_d = ST_BOFF;
        else if (pend_i)      state_d = ST_ADDR;
        else if (hold_i)      state_d = ST_HELD;
        else if (req_valid_i) begin
          load_o  = 1'b1;
          state_d = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (!boff_ni) state_d = ST_BOFF;
        else          state_d = ST_DATA;
      end
      ST_DATA: begin
        if (!boff_ni) state_d = ST_BOFF;
        else if (!rdy_ni) begin
          clear_o = 1'b1;
          state_d = hold_i ? ST_HELD : ST_IDLE;
        end
      end
      ST_HELD: begin
        if (!hold_i) state_d = ST_IDLE;
      end
      ST_BOFF: begin
        if (boff_ni) begin
          if (pend_i)      state_d = ST_ADDR;
          else if (hold_i) state_d = ST_HELD;
          else             state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_d_o   = state_d;
  assign req_ready_o = (state_q == ST_IDLE) && !pend_i && boff_ni && !hold_i;
  assign rsp_valid_o = (state_q == ST_DATA) && boff_ni && !rdy_ni;

  AST_WAIT_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && rdy_ni && boff_ni) |=> (state_q == ST_DATA)); // R3
  AST_RSP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R3
  AST_BOFF_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_cycle(state_q) && !boff_ni) |=> (state_q == ST_BOFF && pend_i)); // R7
  AST_HELD_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HELD) |-> !pend_i); // R9
  AST_HOLD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HELD && !hold_i) |=> (state_q == ST_IDLE)); // R6
  AST_REPLAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BOFF && boff_ni && pend_i) |=> (state_q == ST_ADDR)); // R8
endmodule

// File: rtl/bcc_drv.sv
module bcc_drv import bcc_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  bcc_state_e state_d_i,
  input  logic       write_d_i,
  output logic       start_o,
  output logic       hlda_o,
  output logic       addr_oe_o,
  output logic       ctrl_oe_o,
  output logic       data_oe_o
);
  // enables are registered from next state: glitch-free at the pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o   <= 1'b0;
      hlda_o    <= 1'b0;
      addr_oe_o <= 1'b0;
      ctrl_oe_o <= 1'b0;
      data_oe_o <= 1'b0;
    end else begin
      start_o   <= (state_d_i == ST_ADDR);
      hlda_o    <= (state_d_i == ST_HELD);
      addr_oe_o <= drives_bus(state_d_i);
      ctrl_oe_o <= drives_bus(state_d_i);
      data_oe_o <= in_cycle(state_d_i) && write_d_i;
    end
  end

  AST_FLOAT_ON_HLDA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (!addr_oe_o && !ctrl_oe_o && !data_oe_o)); // R5
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> addr_oe_o); // R2
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl import bcc_pkg::*; #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_write_i,
  input  logic          req_mem_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          bus_write_o,
  output logic          bus_mem_o,
  output logic          bus_start_o,
  input  logic          bus_rdy_ni,
  output logic          bus_req_o,
  input  logic          hold_i,
  output logic          hlda_o,
  input  logic          boff_ni,
  output logic          addr_oe_o,
  output logic          data_oe_o,
  output logic          ctrl_oe_o
);
  bcc_state_e state_d;
  logic       load, clear, pend, cyc_write, write_d;

  bcc_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .pend_i      (pend),
    .rdy_ni      (bus_rdy_ni),
    .hold_i      (hold_i),
    .boff_ni     (boff_ni),
    .state_d_o   (state_d),
    .load_o      (load),
    .clear_o     (clear),
    .req_ready_o (req_ready_o),
    .rsp_valid_o (rsp_valid_o)
  );

  bcc_cycle_reg #(.AW(AW), .DW(DW)) u_cyc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .clear_i (clear),
    .addr_i  (req_addr_i),
    .write_i (req_write_i),
    .mem_i   (req_mem_i),
    .wdata_i (req_wdata_i),
    .pend_o  (pend),
    .addr_o  (bus_addr_o),
    .write_o (cyc_write),
    .mem_o   (bus_mem_o),
    .wdata_o (bus_wdata_o)
  );

  assign write_d = load ? req_write_i : cyc_write;

  bcc_drv u_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_d_i (state_d),
    .write_d_i (write_d),
    .start_o   (bus_start_o),
    .hlda_o    (hlda_o),
    .addr_oe_o (addr_oe_o),
    .ctrl_oe_o (ctrl_oe_o),
    .data_oe_o (data_oe_o)
  );

  assign bus_write_o = cyc_write;
  assign bus_req_o   = pend;
  assign rsp_rdata_o = bus_rdata_i;

  AST_NO_HLDA_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> !bus_req_o); // R9
  AST_REQ_UNTIL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !rsp_valid_o) |=> bus_req_o); // R4
  AST_ACCEPT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!bus_req_o && !hlda_o && boff_ni)); // R2
endmodule

// File: tb/test_bus_cycle_ctrl.sv
module test_bus_cycle_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_write_i = 1'b0, req_mem_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic bus_rdy_ni = 1'b1, hold_i = 1'b0, boff_ni = 1'b1;
  logic req_ready_o, rsp_valid_o, bus_write_o, bus_mem_o, bus_start_o, bus_req_o;
  logic hlda_o, addr_oe_o, data_oe_o, ctrl_oe_o;
  logic [DW-1:0] rsp_rdata_o, bus_wdata_o, bus_rdata_i;
  logic [AW-1:0] bus_addr_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
    return {a[15:0], a[31:16]} ^ 32'hC3A5_0F1E;
  endfunction

  assign bus_rdata_i = exp_rd(bus_addr_o);

  bus_cycle_ctrl #(.AW(AW), .DW(DW)) i_bus_cycle_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_write_i(req_write_i), .req_mem_i(req_mem_i),
    .req_wdata_i(req_wdata_i), .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i),
    .bus_write_o(bus_write_o), .bus_mem_o(bus_mem_o), .bus_start_o(bus_start_o),
    .bus_rdy_ni(bus_rdy_ni), .bus_req_o(bus_req_o), .hold_i(hold_i), .hlda_o(hlda_o),
    .boff_ni(boff_ni), .addr_oe_o(addr_oe_o), .data_oe_o(data_oe_o), .ctrl_oe_o(ctrl_oe_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // one request through the bus; waits = data-phase wait states,
  // boff_at / hold_at = phase index (0 = address phase) at which to assert, -1 = never
  task automatic run_cycle(input logic [AW-1:0] a, input bit wr, input bit mem,
                           input logic [DW-1:0] wd, input int waits,
                           input int boff_at, input int boff_len,
                           input int hold_at, input int hold_len);
    int k = 0;
    int starts = 0;
    int boff_left = 0;
    bit aborted = 0;
    bit done = 0;
    int exp_starts;
    exp_starts = (boff_at >= 0 && boff_at <= waits + 1) ? 2 : 1;
    req_addr_i = a; req_write_i = wr; req_mem_i = mem; req_wdata_i = wd;
    req_valid_i = 1'b1;
    #1 chk(req_ready_o == 1'b1, "R2 ready when idle", {63'd0, req_ready_o}, 64'd1);
    @(negedge clk);
    req_valid_i = 1'b0;
    while (!done) begin
      if (boff_left > 0) begin
        chk(!addr_oe_o && !ctrl_oe_o && !data_oe_o, "R7 floated on backoff",
            {61'd0, addr_oe_o, ctrl_oe_o, data_oe_o}, 64'd0);
        chk(bus_req_o == 1'b1, "R7 request kept", {63'd0, bus_req_o}, 64'd1);
        if (hold_i) chk(hlda_o == 1'b0, "R9 no hlda in backoff", {63'd0, hlda_o}, 64'd0);
        boff_left--;
        if (boff_left == 0) boff_ni = 1'b1;
        @(negedge clk);
        continue;
      end
      if (k == 0) begin
        starts++;
        chk(bus_start_o == 1'b1, "R8 start strobe", {63'd0, bus_start_o}, 64'd1);
        chk(bus_addr_o == a && bus_write_o == wr && bus_mem_o == mem, "R2 cycle fields",
            {30'd0, bus_write_o, bus_mem_o, bus_addr_o}, {30'd0, wr, mem, a});
        chk(data_oe_o == wr, "R2 data enable", {63'd0, data_oe_o}, {63'd0, wr});
        if (wr) chk(bus_wdata_o == wd, "R2 write data", {32'd0, bus_wdata_o}, {32'd0, wd});
        chk(req_ready_o == 1'b0, "R2 busy", {63'd0, req_ready_o}, 64'd0);
      end else begin
        chk(!bus_start_o && addr_oe_o && bus_addr_o == a, "R3 wait holds address",
            {30'd0, bus_start_o, addr_oe_o, bus_addr_o}, {30'd0, 1'b0, 1'b1, a});
      end
      chk(bus_req_o == 1'b1, "R4 request high", {63'd0, bus_req_o}, 64'd1);
      if (k == hold_at) hold_i = 1'b1;
      bus_rdy_ni = !(k >= 1 && k - 1 == waits);
      if (!aborted && k == boff_at) begin
        boff_ni = 1'b0;
        aborted = 1;
        boff_left = boff_len;
      end
      #1;
      if (!boff_ni) begin
        chk(rsp_valid_o == 1'b0, "R7 no response on abort", {63'd0, rsp_valid_o}, 64'd0);
      end else if (!bus_rdy_ni) begin
        chk(rsp_valid_o == 1'b1, "R3 response on ready", {63'd0, rsp_valid_o}, 64'd1);
        if (!wr) chk(rsp_rdata_o == exp_rd(a), "R3 read data",
                     {32'd0, rsp_rdata_o}, {32'd0, exp_rd(a)});
        done = 1;
      end else begin
        chk(rsp_valid_o == 1'b0, "R3 no response in wait", {63'd0, rsp_valid_o}, 64'd0);
      end
      @(negedge clk);
      bus_rdy_ni = 1'b1;
      if (!boff_ni) k = 0;
      else k++;
    end
    chk(bus_req_o == 1'b0, "R4 request drops", {63'd0, bus_req_o}, 64'd0);
    chk(starts == exp_starts, "R8 start count", 64'(starts), 64'(exp_starts));
    if (hold_i) begin
      chk(hlda_o && !addr_oe_o && !ctrl_oe_o && !data_oe_o, "R5 hold acknowledged",
          {60'd0, hlda_o, addr_oe_o, ctrl_oe_o, data_oe_o}, 64'h8);
      for (int i = 0; i < hold_len; i++) begin
        @(negedge clk);
        chk(hlda_o == 1'b1, "R5 hold kept", {63'd0, hlda_o}, 64'd1);
      end
      hold_i = 1'b0;
      @(negedge clk);
      chk(!hlda_o && addr_oe_o && ctrl_oe_o, "R6 release",
          {61'd0, hlda_o, addr_oe_o, ctrl_oe_o}, 64'h3);
    end else begin
      chk(!hlda_o && addr_oe_o && ctrl_oe_o, "R4 idle drives bus",
          {61'd0, hlda_o, addr_oe_o, ctrl_oe_o}, 64'h3);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    chk(!addr_oe_o && !data_oe_o && !ctrl_oe_o && !hlda_o && !bus_req_o && !bus_start_o,
        "R1 reset state",
        {58'd0, addr_oe_o, data_oe_o, ctrl_oe_o, hlda_o, bus_req_o, bus_start_o}, 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // directed: zero-wait read, three-wait write
    run_cycle(32'h0000_1000, 1'b0, 1'b1, 32'h0, 0, -1, 0, -1, 0);
    run_cycle(32'h0000_2004, 1'b1, 1'b0, 32'hDEAD_BEEF, 3, -1, 0, -1, 0);
    // backoff in address phase; backoff with ready in same clock
    run_cycle(32'h0000_3008, 1'b0, 1'b1, 32'h0, 1, 0, 2, -1, 0);
    run_cycle(32'h0000_400C, 1'b1, 1'b1, 32'h1234_5678, 2, 3, 1, -1, 0);
    // hold during wait; hold together with backoff
    run_cycle(32'h0000_5010, 1'b0, 1'b0, 32'h0, 2, -1, 0, 1, 2);
    run_cycle(32'h0000_6014, 1'b1, 1'b1, 32'hA5A5_5A5A, 1, 1, 2, 0, 1);

    // hold while idle
    hold_i = 1'b1;
    #1 chk(req_ready_o == 1'b0, "R2 not ready under hold", {63'd0, req_ready_o}, 64'd0);
    @(negedge clk);
    chk(hlda_o && !addr_oe_o, "R5 idle hold", {62'd0, hlda_o, addr_oe_o}, 64'h2);
    hold_i = 1'b0;
    @(negedge clk);
    chk(!hlda_o && addr_oe_o, "R6 idle release", {62'd0, hlda_o, addr_oe_o}, 64'h1);

    // hold and backoff together while idle
    hold_i = 1'b1;
    boff_ni = 1'b0;
    @(negedge clk);
    chk(!hlda_o && !addr_oe_o, "R9 backoff wins", {62'd0, hlda_o, addr_oe_o}, 64'd0);
    boff_ni = 1'b1;
    @(negedge clk);
    chk(hlda_o == 1'b1, "R9 hlda after backoff", {63'd0, hlda_o}, 64'd1);
    hold_i = 1'b0;
    @(negedge clk);
    chk(!hlda_o && ctrl_oe_o, "R6 release after backoff", {62'd0, hlda_o, ctrl_oe_o}, 64'h1);

    // constrained random
    for (int t = 0; t < 150; t++) begin
      int w, ba, bl, ha, hl;
      logic [AW-1:0] a;
      w  = int'($urandom % 4);
      ba = ($urandom % 3 == 0) ? int'($urandom % (w + 2)) : -1;
      bl = 1 + int'($urandom % 3);
      ha = ($urandom % 4 == 0) ? int'($urandom % (w + 2)) : -1;
      hl = 1 + int'($urandom % 3);
      a  = $urandom & 32'hFFFF_FFFC;
      run_cycle(a, 1'($urandom), 1'($urandom), $urandom, w, ba, bl, ha, hl);
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule